// File: doc/BRIEF.md
# Bit-Addressable Window onto a Byte Store

The block makes a byte-wide storage array look like a memory one bit wide. Each byte holds eight neighbouring bit locations. A bit address therefore has two parts. The upper part picks the byte. The lowest three bits pick one bit inside that byte, using an 8-to-1 selector on the byte that comes back from the array.

Reads are single-cycle requests. Writes cannot change one bit of the array directly. Each write runs as a short fixed sequence:

1. Fetch the byte that holds the bit.
2. Patch the chosen bit.
3. Store the whole byte back.

During that sequence a busy flag is raised, and a completion pulse marks the end.

The byte array has `BYTE_AW` address bits and bytes of `BYTE_W` = 8 bits. With `BYTE_AW` = 13 the array is 8K x 8 and the bit view is 64K x 1 with a 16-bit bit address. The default build uses a smaller array to keep elaboration light.

Top module: `bitmem_bitview`

## Requirements
- R1: The bit address splits into two fields. Bits [BIT_AW-1:3] are the byte address and bits [2:0] are the bit index, where index 0 is the least significant bit of the byte. So eight consecutive bit addresses map onto one byte.
- R2: A read is a request with `req_i`=1 and `we_i`=0 while `busy_o` is low. In the clock cycle after it is accepted, `rvalid_o` is high for that one cycle and `rdata_o` carries the addressed bit.
- R3: A write is a request with `req_i`=1 and `we_i`=1 while `busy_o` is low. It stores `wdata_i` at the addressed bit and leaves the other seven bits of the same byte unchanged.
- R4: After an accepted write, `busy_o` is high for exactly the two following cycles (the read phase and the modify/write phase), and then drops.
- R5: `done_o` pulses high for exactly one cycle, in the cycle right after `busy_o` falls. By that cycle the byte has already been written back.
- R6: Any request made while `busy_o` is high is ignored. Such a request writes nothing and produces no `rvalid_o` pulse.
- R7: A write whose value equals the stored bit still runs the full sequence, with the same `busy_o` and `done_o` timing.
- R8: While `rst_ni` is low, `busy_o`, `done_o` and `rvalid_o` are low.
- R9: Reads can be issued on every cycle. Each accepted read gets its own `rvalid_o` cycle with its own bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| we_i | input | 1 | 1 = write request, 0 = read request |
| addr_i | input | BIT_AW (BYTE_AW+3) | Bit address |
| wdata_i | input | 1 | Bit value to write |
| rdata_o | output | 1 | Read bit, meaningful while rvalid_o is high |
| rvalid_o | output | 1 | Read result valid, one cycle |
| busy_o | output | 1 | Write sequence in progress |
| done_o | output | 1 | Write completed, one cycle |

## Verification
A read result is due in the first cycle after the edge that accepts it. The bench drives inputs on falling edges and samples `rvalid_o` and `rdata_o` on the next falling edge. For a write, `busy_o` is checked high on the first and second falling edges after acceptance, and low on the third, where `done_o` must be high. `done_o` must be low again on the fourth. The bench sweeps every bit address of a 64-bit configuration with arithmetic patterns and keeps a model of the bits, so that neighbours in each byte are checked after every overwrite. Requests made inside the busy window are then checked at the ports: no `rvalid_o`, and the targeted bit read back unchanged.

// File: rtl/bitmem_pkg.sv
package bitmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_MW   = 2'd2,
    ST_DONE = 2'd3
  } wr_st_e;
endpackage

// File: rtl/bitmem_addr_split.sv
module bitmem_addr_split #(
  parameter int BYTE_AW = 10,
  parameter int IDX_W   = 3,
  localparam int BIT_AW = BYTE_AW + IDX_W
) (
  input  logic [BIT_AW-1:0]  addr_i,
  output logic [BYTE_AW-1:0] byte_addr_o,
  output logic [IDX_W-1:0]   idx_o
);
  assign byte_addr_o = addr_i[BIT_AW-1:IDX_W];
  assign idx_o       = addr_i[IDX_W-1:0];
endmodule

// File: rtl/bitmem_bit_sel.sv
module bitmem_bit_sel #(
  parameter int BYTE_W = 8,
  localparam int IDX_W = $clog2(BYTE_W)
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);
  always_comb begin
    bit_o = 1'b0;
    for (int i = 0; i < BYTE_W; i++)
      if (idx_i == IDX_W'(i)) bit_o = byte_i[i];
  end
endmodule

// File: rtl/bitmem_byte_store.sv
module bitmem_byte_store #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk_i,
  input  logic          re_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/bitmem_wr_seq.sv
module bitmem_wr_seq
  import bitmem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic rd_o,
  output logic wr_o
);
  wr_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: st_d = start_i ? ST_RD : ST_IDLE;
      ST_RD:            st_d = ST_MW;
      ST_MW:            st_d = ST_DONE;
      default:          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign rd_o   = (st_q == ST_RD);
  assign wr_o   = (st_q == ST_MW);
  assign busy_o = rd_o | wr_o;
  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/bitmem_bitview.sv
module bitmem_bitview #(
  parameter int BYTE_AW = 10,
  parameter int BYTE_W  = 8,
  localparam int IDX_W  = $clog2(BYTE_W),
  localparam int BIT_AW = BYTE_AW + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [BIT_AW-1:0] addr_i,
  input  logic              wdata_i,
  output logic              rdata_o,
  output logic              rvalid_o,
  output logic              busy_o,
  output logic              done_o
);
  logic [BYTE_AW-1:0] in_byte, byte_q, st_addr;
  logic [IDX_W-1:0]   in_idx, idx_q;
  logic               wbit_q, rvalid_q;
  logic               accept, rd_go, wr_go;
  logic               seq_busy, seq_rd, seq_wr;
  logic [BYTE_W-1:0]  st_rdata, patched;

  bitmem_addr_split #(.BYTE_AW(BYTE_AW), .IDX_W(IDX_W)) u_split (
    .addr_i(addr_i), .byte_addr_o(in_byte), .idx_o(in_idx)
  );

  assign accept = req_i & ~seq_busy;
  assign rd_go  = accept & ~we_i;
  assign wr_go  = accept & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q   <= '0;
      idx_q    <= '0;
      wbit_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_go;
      if (accept) begin
        byte_q <= in_byte;
        idx_q  <= in_idx;
        wbit_q <= wdata_i;
      end
    end
  end

  bitmem_wr_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(wr_go),
    .busy_o(seq_busy), .done_o(done_o), .rd_o(seq_rd), .wr_o(seq_wr)
  );

  // During a write sequence the array follows the latched byte address
  assign st_addr = seq_busy ? byte_q : in_byte;

  bitmem_byte_store #(.AW(BYTE_AW), .DW(BYTE_W)) u_store (
    .clk_i(clk_i), .re_i(rd_go | seq_rd), .we_i(seq_wr),
    .addr_i(st_addr), .wdata_i(patched), .rdata_o(st_rdata)
  );

  for (genvar g = 0; g < BYTE_W; g++) begin : g_patch
    assign patched[g] = (idx_q == IDX_W'(g)) ? wbit_q : st_rdata[g];
  end

  bitmem_bit_sel #(.BYTE_W(BYTE_W)) u_sel (
    .byte_i(st_rdata), .idx_i(idx_q), .bit_o(rdata_o)
  );

  assign rvalid_o = rvalid_q;
  assign busy_o   = seq_busy;
endmodule

// File: rtl/bitmem_bitview_chk.sv
module bitmem_bitview_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic we_i,
  input logic rvalid_o,
  input logic busy_o,
  input logic done_o
);
  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !busy_o) |=> rvalid_o);

  // R2
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i && !busy_o));

  // R4
  wr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !busy_o) |=> busy_o);

  // R4
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> busy_o);

  // R4
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |=> !busy_o);

  // R5
  done_after_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && busy_o) |=> !rvalid_o);

  // R8
  always @(posedge clk_i)
    if (!rst_ni) reset_quiet_chk: assert (!busy_o && !done_o && !rvalid_o);
endmodule

bind bitmem_bitview bitmem_bitview_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .rvalid_o(rvalid_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/bitmem_bitview_tb.sv
module bitmem_bitview_tb;
  localparam int BYTE_AW = 3;
  localparam int BIT_AW  = BYTE_AW + 3;
  localparam int NBITS   = 1 << BIT_AW;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, wdata_i = 1'b0;
  logic [BIT_AW-1:0] addr_i = '0;
  logic rdata_o, rvalid_o, busy_o, done_o;

  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;
  bit model [NBITS];

  always #10 clk_i = ~clk_i;

  bitmem_bitview #(.BYTE_AW(BYTE_AW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .busy_o(busy_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  function automatic bit pat(input int a, input int k);
    return 1'(((a * 7 + k) >> 2) ^ a ^ k);
  endfunction

  // R3 R4 R5 R7: write with fixed-latency handshake checks
  task automatic do_write(input int a, input bit v);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = BIT_AW'(a); wdata_i = v;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(busy_o == 1'b1, "R4 busy c1", busy_o, 1);
    chk(done_o == 1'b0, "R5 done c1", done_o, 0);
    @(negedge clk_i);
    chk(busy_o == 1'b1, "R4 busy c2", busy_o, 1);
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R4 busy c3", busy_o, 0);
    chk(done_o == 1'b1, "R5 done c3", done_o, 1);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R5 done c4", done_o, 0);
    model[a] = v;
  endtask

  // R1 R2 R9: back-to-back read sweep over all bit addresses
  task automatic sweep_read(input string tag);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = '0;
    for (int i = 0; i < NBITS; i++) begin
      @(negedge clk_i);
      chk(rvalid_o == 1'b1, "R9 rvalid", rvalid_o, 1);
      if (rdata_o !== model[i])
        $display("FAIL R1/R2 %s addr %0d: actual %0d expected %0d", tag, i, rdata_o, model[i]);
      n_run++;
      if (rdata_o !== model[i]) n_fail++;
      if (i < NBITS - 1) addr_i = BIT_AW'(i + 1);
      else req_i = 1'b0;
    end
    @(negedge clk_i);
    chk(rvalid_o == 1'b0, "R2 single pulse", rvalid_o, 0);
  endtask

  task automatic read_one(input int a, input string rq);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = BIT_AW'(a);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(rvalid_o == 1'b1, rq, rvalid_o, 1);
    chk(rdata_o == model[a], rq, rdata_o, model[a]);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R8
    chk(busy_o == 1'b0, "R8 busy", busy_o, 0);
    chk(done_o == 1'b0, "R8 done", done_o, 0);
    chk(rvalid_o == 1'b0, "R8 rvalid", rvalid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int a = 0; a < NBITS; a++) do_write(a, pat(a, 0));
    sweep_read("pass0");

    // R3: flip every third bit, neighbours must hold
    for (int a = 0; a < NBITS; a += 3) do_write(a, ~model[a]);
    sweep_read("pass1");

    // R1: all bits of byte 5 set, then clear bit index 0 (LSB) only
    for (int b = 0; b < 8; b++) do_write(5 * 8 + b, 1'b1);
    do_write(5 * 8, 1'b0);
    read_one(5 * 8, "R1 lsb cleared");
    read_one(5 * 8 + 7, "R1 msb kept");

    // R7: same-value writes, timing checked inside do_write
    for (int a = 10; a < 14; a++) do_write(a, model[a]);
    sweep_read("pass2");

    // R6: write request and read request made inside the busy window
    begin
      bit old_b;
      old_b = model[20];
      @(negedge clk_i);
      req_i = 1'b1; we_i = 1'b1; addr_i = BIT_AW'(33); wdata_i = ~model[33];
      @(negedge clk_i);
      model[33] = ~model[33];
      addr_i = BIT_AW'(20); wdata_i = ~old_b;
      chk(busy_o == 1'b1, "R6 busy", busy_o, 1);
      @(negedge clk_i);
      we_i = 1'b0;
      chk(rvalid_o == 1'b0, "R6 no rvalid", rvalid_o, 0);
      @(negedge clk_i);
      req_i = 1'b0;
      chk(rvalid_o == 1'b0, "R6 no rvalid on read", rvalid_o, 0);
      chk(done_o == 1'b1, "R5 done", done_o, 1);
      read_one(20, "R6 ignored write");
      read_one(33, "R3 accepted write");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule